// File: doc/BRIEF.md
# Select-Line Multiplexed Serial Word Link

This block moves a 16-bit parallel word from a source to a destination register over a narrow link made of one data wire and a 4-bit select bus. On the sending side, a multiplexer puts the source bit chosen by the select value onto the data wire. On the receiving side, a demultiplexer uses the same select value to write that bit into the matching position of the destination register. The position of each bit is carried openly on the select bus. It is not implied by a shift order.

A request carries a starting bit index and a bit count. The sequencer then walks the select bus upward from the start index, one position per clock, so a single request can move the whole word or any run of 1 to 16 bits. The source word is copied into a holding register when the request is accepted. One clock after the last bit is captured, a done pulse is raised. While a transfer is running, new requests are refused.

Top module: `mux_serial_link`

## Requirements
- R1: After a synchronous reset, rx_word_o is 0, link_sel_o is 0, link_data_o is 0, and busy_o and done_o are both low.
- R2: An accepted request puts start_idx_i on link_sel_o in the next cycle. Each later busy cycle shows the previous select value plus one.
- R3: While busy_o is high, link_data_o equals the bit of the held source word at position link_sel_o. While busy_o is low, link_data_o is 0.
- R4: On each clock edge where busy_o is high, bit link_sel_o of rx_word_o takes the value of link_data_o. Every other bit keeps its value, and rx_word_o does not change on edges where busy_o is low.
- R5: A request with start 0 and count 16 keeps busy_o high for 16 cycles, with select values 0 to 15 in order. Afterwards rx_word_o equals the source word.
- R6: busy_o stays high for exactly the effective count of cycles.
- R7: done_o is high for one cycle only: the cycle right after the last busy cycle. While idle, link_sel_o holds the last index sent.
- R8: If start_idx_i plus count_i exceeds 16, the effective count becomes 16 minus start_idx_i, so bit 15 is the last bit sent.
- R9: start_i is ignored while busy_o is high. The running transfer's select sequence and length are not affected.
- R10: The source word is sampled at acceptance. Changes to src_word_i during a transfer do not affect the bits sent.
- R11: A request with count_i equal to 0 is ignored: busy_o stays low and rx_word_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, accepted when idle |
| start_idx_i | input | 4 | First bit index of the run |
| count_i | input | 5 | Requested bit count (0 means no transfer) |
| src_word_i | input | 16 | Source word to send |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse after the final capture |
| link_data_o | output | 1 | Serial data wire |
| link_sel_o | output | 4 | Select bus shared by both ends |
| rx_word_o | output | 16 | Destination register |

## Verification
The assertions assume that reset is asserted from time zero for at least one edge. They also assume that a transfer cannot start in the same cycle another one ends, since a request is only taken while busy_o is low. Because of this, consecutive busy cycles always belong to one transfer, and the select step check never spans two transfers. The stimulus drives requests only on falling edges and includes requests made in the done cycle. It also pokes start_i and src_word_i during transfers and uses counts above the room left in the word. All of these stay within the accepted-request rule that the checks rely on.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } link_state_e;
endpackage

// File: rtl/link_seq.sv
module link_seq #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = $clog2(WORD_W),
  parameter int CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  start_idx_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] src_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [WORD_W-1:0] hold_o
);
  import link_pkg::*;

  link_state_e       state_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] hold_q;
  logic              done_q;

  logic [CNT_W-1:0]  room;
  logic [CNT_W-1:0]  eff_cnt;
  logic              accept;
  logic              last_bit;

  // bits remaining from the start index to the top of the word
  assign room     = CNT_W'(WORD_W) - CNT_W'(start_idx_i);
  assign eff_cnt  = (count_i > room) ? room : count_i;
  assign accept   = start_i && (state_q == ST_IDLE) && (count_i != '0);
  assign last_bit = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      left_q  <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_SEND;
        sel_q   <= start_idx_i;
        left_q  <= eff_cnt;
        hold_q  <= src_word_i;
      end else if (state_q == ST_SEND) begin
        left_q <= left_q - CNT_W'(1);
        if (last_bit) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          sel_q <= sel_q + SEL_W'(1);
        end
      end
    end
  end

  assign busy_o = (state_q == ST_SEND);
  assign done_o = done_q;
  assign sel_o  = sel_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/link_tx_mux.sv
module link_tx_mux #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              en_i,
  output logic              data_o
);
  assign data_o = en_i & word_i[sel_i];
endmodule

// File: rtl/link_rx_demux.sv
module link_rx_demux #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] wr_en;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign wr_en[b] = en_i && (sel_i == SEL_W'(b));
    always_ff @(posedge clk) begin
      if (rst)           word_o[b] <= 1'b0;
      else if (wr_en[b]) word_o[b] <= data_i;
    end
  end
endmodule

// File: rtl/mux_serial_link.sv
module mux_serial_link #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = $clog2(WORD_W),
  parameter int CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  start_idx_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] src_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              link_data_o,
  output logic [SEL_W-1:0]  link_sel_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] hold_w;

  link_seq #(.WORD_W(WORD_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_idx_i (start_idx_i),
    .count_i     (count_i),
    .src_word_i  (src_word_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .sel_o       (link_sel_o),
    .hold_o      (hold_w)
  );

  link_tx_mux #(.WORD_W(WORD_W), .SEL_W(SEL_W)) tx_i (
    .word_i (hold_w),
    .sel_i  (link_sel_o),
    .en_i   (busy_o),
    .data_o (link_data_o)
  );

  link_rx_demux #(.WORD_W(WORD_W), .SEL_W(SEL_W)) rx_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (busy_o),
    .sel_i  (link_sel_o),
    .data_i (link_data_o),
    .word_o (rx_word_o)
  );
endmodule

// File: rtl/link_chk.sv
module link_chk #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic              link_data_o,
  input logic [SEL_W-1:0]  link_sel_o,
  input logic [WORD_W-1:0] rx_word_o
);
  // R2
  sel_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (!busy_o || (link_sel_o == SEL_W'($past(link_sel_o) + 1'b1))));

  // R3
  idle_data_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !link_data_o);

  // R4
  rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (rx_word_o[$past(link_sel_o)] == $past(link_data_o)));

  // R4
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> $stable(rx_word_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7
  sel_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> (busy_o || $stable(link_sel_o)));
endmodule

bind mux_serial_link link_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .link_data_o (link_data_o),
  .link_sel_o  (link_sel_o),
  .rx_word_o   (rx_word_o)
);

// File: tb/mux_serial_link_tb_top.sv
module mux_serial_link_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_r = 1'b0;
  logic [3:0]  idx_r = '0;
  logic [4:0]  cnt_r = '0;
  logic [15:0] src_r = '0;
  logic        busy_o, done_o, link_data_o;
  logic [3:0]  link_sel_o;
  logic [15:0] rx_word_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mux_serial_link dut_i (
    .clk(clk), .rst(rst), .start_i(start_r), .start_idx_i(idx_r),
    .count_i(cnt_r), .src_word_i(src_r), .busy_o(busy_o), .done_o(done_o),
    .link_data_o(link_data_o), .link_sel_o(link_sel_o), .rx_word_o(rx_word_o)
  );

  // behavioural reference: a queue of bit indices still to be sent
  int          q[$];
  logic [15:0] m_rx, m_hold;
  int          m_last;
  logic        m_done;

  always @(posedge clk) begin
    int b;
    int n;
    if (rst) begin
      q.delete();
      m_rx = '0; m_hold = '0; m_last = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (q.size() != 0) begin
        b = q.pop_front();
        m_rx[b] = m_hold[b];
        m_last = b;
        if (q.size() == 0) m_done = 1'b1;
      end else if (start_r && cnt_r != 0) begin
        n = int'(cnt_r);
        if (n > 16 - int'(idx_r)) n = 16 - int'(idx_r);
        m_hold = src_r;
        for (int k = 0; k < n; k++) q.push_back(int'(idx_r) + k);
        m_last = int'(idx_r);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    logic eb;
    eb = (q.size() != 0);
    chk("R6 busy", 32'(busy_o), 32'(eb));
    chk("R7 done", 32'(done_o), 32'(m_done));
    chk("R2 sel", 32'(link_sel_o), eb ? 32'(q[0]) : 32'(m_last));
    chk("R3 data", 32'(link_data_o), eb ? 32'(m_hold[q[0]]) : 32'd0);
    chk("R4 rx", 32'(rx_word_o), 32'(m_rx));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_model();
  endtask

  // issue one request, wait for the end, return busy cycles
  task automatic xfer(input logic [3:0] i, input logic [4:0] c,
                      input logic [15:0] s, output int ncyc);
    idx_r = i; cnt_r = c; src_r = s; start_r = 1'b1;
    tick();
    start_r = 1'b0;
    ncyc = 0;
    while (busy_o && ncyc < 40) begin
      ncyc++;
      tick();
    end
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 rx", 32'(rx_word_o), 32'd0);
    chk("R1 sel", 32'(link_sel_o), 32'd0);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 data", 32'(link_data_o), 32'd0);
    tick();

    // R5 full word
    xfer(4'd0, 5'd16, 16'hA5C3, n);
    chk("R5 cycles", 32'(n), 32'd16);
    chk("R5 rx", 32'(rx_word_o), 32'hA5C3);
    chk("R7 done", 32'(done_o), 32'd1);
    chk("R7 sel idle", 32'(link_sel_o), 32'd15);
    tick();

    // R4 partial run, other bits kept
    xfer(4'd4, 5'd4, 16'hFFFF, n);
    chk("R6 cycles", 32'(n), 32'd4);
    chk("R4 rx", 32'(rx_word_o), 32'hA5F3);

    // R8 clipping, started in the done cycle
    xfer(4'd12, 5'd10, 16'h0000, n);
    chk("R8 cycles", 32'(n), 32'd4);
    chk("R8 rx", 32'(rx_word_o), 32'h05F3);
    chk("R8 last sel", 32'(link_sel_o), 32'd15);
    tick();

    // R9 and R10: pokes and source changes during the transfer
    idx_r = 4'd0; cnt_r = 5'd8; src_r = 16'h00FF; start_r = 1'b1;
    tick();
    n = 0;
    while (busy_o && n < 40) begin
      n++;
      start_r = 1'b1; idx_r = 4'd9; cnt_r = 5'd3; src_r = 16'h0000;
      tick();
    end
    start_r = 1'b0;
    chk("R9 cycles", 32'(n), 32'd8);
    chk("R10 rx", 32'(rx_word_o), 32'h05FF);
    tick();

    // R11 zero count
    idx_r = 4'd2; cnt_r = 5'd0; src_r = 16'h0000; start_r = 1'b1;
    tick();
    start_r = 1'b0;
    chk("R11 busy", 32'(busy_o), 32'd0);
    tick();
    chk("R11 rx", 32'(rx_word_o), 32'h05FF);

    // R8 single top bit
    xfer(4'd15, 5'd1, 16'h8000, n);
    chk("R8 one bit", 32'(n), 32'd1);
    chk("R4 rx top", 32'(rx_word_o), 32'h85FF);

    // mixed requests checked against the reference every cycle
    for (int t = 0; t < 40; t++) begin
      idx_r = 4'($urandom_range(0, 15));
      cnt_r = 5'($urandom_range(0, 20));
      src_r = 16'($urandom);
      start_r = 1'b1;
      tick();
      start_r = 1'($urandom_range(0, 1));
      while (busy_o) begin
        src_r = 16'($urandom);
        start_r = 1'($urandom_range(0, 1));
        tick();
      end
      start_r = 1'b0;
      if ($urandom_range(0, 1) == 1) tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule